// File: doc/BRIEF.md
# TCP Session State Tracker

This block follows TCP connections through a small on-chip session table. A packet descriptor is offered on a valid/ready handshake. It carries the connection 5-tuple, the SYN, ACK and RST flag bits, the sequence and acknowledge numbers, the payload length, the advertised window and the IP TTL. The block compares the descriptor against every live entry at once, in both the forward and the reversed orientation. It then moves the matching entry through the opening handshake and reports one result per packet. The result holds a hit flag, an established flag, a client-to-server direction flag, a forward/drop decision, the slot used and three anomaly alert bits.

Every entry is free, waiting for a SYN/ACK, waiting for the final ACK, or established. Each entry carries a last-access timestamp taken from a free-running tick counter, so within any state the oldest timestamp marks the least recently used entry. Half-open entries expire sooner than established ones. A bare SYN that misses the table claims a slot. When no slot is free, an expired entry or, failing that, the least recently used established entry gives way.

Top module: `tcp_flow_tracker`

## Requirements
- R1: After reset, in_ready is high, res_valid is low and every slot is free, so the first bare SYN receives slot 0.
- R2: A bare SYN (in_syn=1, in_ack_flag=0) that misses claims a slot and sets res_new. A SYN+ACK that matches that entry in the reversed orientation moves it to the wait-for-ACK state. A later forward packet with ACK and without SYN makes it established. res_est is 1 only for a hit on an entry that was already established before the packet.
- R3: res_c2s is 1 for a forward-orientation hit and 0 for a reversed hit. On a miss it is 1 only for a bare SYN.
- R4: A packet with in_syn=1 can match only entries that are still mid-handshake. A SYN for a key that is established misses and claims a new slot.
- R5: A hit is always forwarded (res_fwd=1). A miss is forwarded only when cfg_miss_pass=1, and then res_est=0. A miss that is not a bare SYN never claims a slot.
- R6: res_alert[0] is set on a hit whose sequence number is below, unsigned, the last acknowledge number recorded from the opposite direction. Only packets with the ACK flag record an acknowledge number.
- R7: res_alert[1] is set on a hit whose payload length exceeds the window most recently advertised by the opposite direction.
- R8: res_alert[2] is set on a hit whose TTL differs by more than cfg_ttl_thresh from the TTL of the first packet seen in the same direction of that session.
- R9: An entry whose age in ticks exceeds the limit for its state (TO_EMB while mid-handshake, TO_EST once established) no longer matches any packet.
- R10: A new session takes the lowest free slot first. On a full table it takes the oldest expired entry in the SYN-wait state, then in the ACK-wait state, then among established entries. If none has expired it takes the least recently used established entry. If there is no established entry it gets no slot (res_new=0).
- R11: Every hit refreshes the entry's timestamp, so a touched established entry is not the eviction choice.
- R12: A hit carrying RST frees the entry. Later non-SYN packets for that key miss, and the slot becomes free for the next new session.
- R13: Once a descriptor is accepted, in_ready is low for the next cycle. res_valid is high for exactly one cycle, two clock edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be accepted this cycle |
| in_proto | input | 8 | IP protocol field of the key |
| in_src_ip | input | 32 | Source address |
| in_dst_ip | input | 32 | Destination address |
| in_src_port | input | 16 | Source port |
| in_dst_port | input | 16 | Destination port |
| in_syn | input | 1 | SYN flag |
| in_ack_flag | input | 1 | ACK flag |
| in_rst | input | 1 | RST flag |
| in_seq | input | 32 | Sequence number |
| in_ack | input | 32 | Acknowledge number |
| in_len | input | 16 | Payload length in bytes |
| in_win | input | 16 | Advertised window |
| in_ttl | input | 8 | IP TTL |
| cfg_ttl_thresh | input | 8 | Largest TTL change that raises no alert |
| cfg_miss_pass | input | 1 | 1 forwards missing packets, 0 drops them |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Packet matched a live entry |
| res_new | output | 1 | Packet opened a new entry |
| res_slot | output | SW | Slot that was hit or claimed |
| res_fwd | output | 1 | Packet is forwarded |
| res_est | output | 1 | Packet belongs to an established session |
| res_c2s | output | 1 | Packet travels client to server |
| res_alert | output | 3 | TTL, window and sequence alert bits (bit 2..0) |

## Verification
Claiming a slot and evicting a victim happen in the same cycle whenever a bare SYN meets a full table. The bench fills a four-slot table with entries in all three live states and lets the half-open ones expire. It then opens new sessions one by one and judges each res_slot against the tiered order: the older expired SYN-wait entry, the younger one, the expired ACK-wait entry, and finally the established entry that was least recently touched. The sequence and window checks can also fire together on one reversed packet, and the bench expects both bits in that same result.

// File: rtl/tcp_flow_tracker.sv
module tcp_flow_tracker #(
  parameter int N      = 16,
  parameter int TW     = 32,
  parameter int TO_EMB = 2000,
  parameter int TO_EST = 200000,
  localparam int SW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_proto,
  input  logic [31:0]   in_src_ip,
  input  logic [31:0]   in_dst_ip,
  input  logic [15:0]   in_src_port,
  input  logic [15:0]   in_dst_port,
  input  logic          in_syn,
  input  logic          in_ack_flag,
  input  logic          in_rst,
  input  logic [31:0]   in_seq,
  input  logic [31:0]   in_ack,
  input  logic [15:0]   in_len,
  input  logic [15:0]   in_win,
  input  logic [7:0]    in_ttl,
  input  logic [7:0]    cfg_ttl_thresh,
  input  logic          cfg_miss_pass,
  output logic          res_valid,
  output logic          res_hit,
  output logic          res_new,
  output logic [SW-1:0] res_slot,
  output logic          res_fwd,
  output logic          res_est,
  output logic          res_c2s,
  output logic [2:0]    res_alert
);
  localparam logic [TW-1:0] LIM_EMB = TW'(TO_EMB);
  localparam logic [TW-1:0] LIM_EST = TW'(TO_EST);
  localparam logic [1:0] S_IDLE = 2'd0, S_SYN = 2'd1, S_SA = 2'd2, S_EST = 2'd3;

  logic          busy;
  logic [103:0]  pk;
  logic          ps, pa, pr;
  logic [31:0]   pseq, pack;
  logic [15:0]   plen, pwin;
  logic [7:0]    pttl;
  logic [TW-1:0] tick;

  logic [103:0]  key_q   [N];
  logic [1:0]    st_q    [N];
  logic [TW-1:0] stamp_q [N];
  logic [31:0]   ack_q   [N][2];
  logic [15:0]   win_q   [N][2];
  logic [7:0]    ttl_q   [N][2];
  logic          ackv_q  [N][2];
  logic          winv_q  [N][2];
  logic          ttlv_q  [N][2];

  assign in_ready = !busy;

  wire [103:0] rk = {pk[103:96], pk[63:32], pk[95:64], pk[15:0], pk[31:16]};
  wire bare_syn = ps && !pa;

  logic [TW-1:0] age [N];
  logic [N-1:0]  expired, fm, rm;
  logic          hit, hfwd, free_ok, eok, room;
  logic [SW-1:0] hidx, free_idx, eidx, vict;
  logic [TW-1:0] eage;
  logic          tok  [4];
  logic [SW-1:0] tidx [4];
  logic [TW-1:0] tage [4];

  always_comb begin
    hit = 1'b0; hfwd = 1'b0; hidx = '0;
    free_ok = 1'b0; free_idx = '0;
    eok = 1'b0; eidx = '0; eage = '0;
    for (int s = 0; s < 4; s++) begin
      tok[s] = 1'b0; tidx[s] = '0; tage[s] = '0;
    end
    for (int i = 0; i < N; i++) begin
      age[i]     = tick - stamp_q[i];
      expired[i] = (st_q[i] != S_IDLE) &&
                   (age[i] > ((st_q[i] == S_EST) ? LIM_EST : LIM_EMB));
      fm[i] = (st_q[i] != S_IDLE) && !expired[i] && (!ps || st_q[i] != S_EST) &&
              (key_q[i] == pk);
      rm[i] = (st_q[i] != S_IDLE) && !expired[i] && (!ps || st_q[i] != S_EST) &&
              (key_q[i] == rk);
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (fm[i] || rm[i]) begin
        hit = 1'b1; hidx = SW'(i); hfwd = fm[i];
      end
      if (st_q[i] == S_IDLE) begin
        free_ok = 1'b1; free_idx = SW'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (expired[i] && (!tok[st_q[i]] || age[i] > tage[st_q[i]])) begin
        tok[st_q[i]] = 1'b1; tidx[st_q[i]] = SW'(i); tage[st_q[i]] = age[i];
      end
      if (st_q[i] == S_EST && (!eok || age[i] > eage)) begin
        eok = 1'b1; eidx = SW'(i); eage = age[i];
      end
    end
    room = 1'b1;
    if (free_ok)               vict = free_idx;
    else if (tok[S_SYN])       vict = tidx[S_SYN];
    else if (tok[S_SA])        vict = tidx[S_SA];
    else if (tok[S_EST])       vict = tidx[S_EST];
    else begin
      vict = eidx; room = eok;
    end
  end

  wire        d  = hfwd;
  wire        od = !hfwd;
  wire [7:0]  trec = ttl_q[hidx][d];
  wire [7:0]  tdif = (pttl > trec) ? pttl - trec : trec - pttl;
  wire        al_seq = ackv_q[hidx][od] && (pseq < ack_q[hidx][od]);
  wire        al_win = winv_q[hidx][od] && (plen > win_q[hidx][od]);
  wire        al_ttl = ttlv_q[hidx][d] && (tdif > cfg_ttl_thresh);
  wire        do_new = !hit && bare_syn && room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pk <= '0; ps <= 1'b0; pa <= 1'b0; pr <= 1'b0;
      pseq <= '0; pack <= '0; plen <= '0; pwin <= '0; pttl <= '0;
    end else if (!busy && in_valid) begin
      busy <= 1'b1;
      pk   <= {in_proto, in_src_ip, in_dst_ip, in_src_port, in_dst_port};
      ps   <= in_syn; pa <= in_ack_flag; pr <= in_rst;
      pseq <= in_seq; pack <= in_ack; plen <= in_len; pwin <= in_win; pttl <= in_ttl;
    end else begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      for (int i = 0; i < N; i++) begin
        key_q[i] <= '0; st_q[i] <= S_IDLE; stamp_q[i] <= '0;
        for (int j = 0; j < 2; j++) begin
          ack_q[i][j] <= '0; win_q[i][j] <= '0; ttl_q[i][j] <= '0;
          ackv_q[i][j] <= 1'b0; winv_q[i][j] <= 1'b0; ttlv_q[i][j] <= 1'b0;
        end
      end
    end else begin
      tick <= tick + 1'b1;
      if (busy && hit) begin
        stamp_q[hidx] <= tick;
        if (pr)
          st_q[hidx] <= S_IDLE;
        else if (st_q[hidx] == S_SYN && ps && pa && !hfwd)
          st_q[hidx] <= S_SA;
        else if (st_q[hidx] == S_SA && !ps && pa && hfwd)
          st_q[hidx] <= S_EST;
        if (pa) begin
          ack_q[hidx][d] <= pack; ackv_q[hidx][d] <= 1'b1;
        end
        win_q[hidx][d] <= pwin; winv_q[hidx][d] <= 1'b1;
        if (!ttlv_q[hidx][d]) begin
          ttl_q[hidx][d] <= pttl; ttlv_q[hidx][d] <= 1'b1;
        end
      end else if (busy && do_new) begin
        key_q[vict] <= pk; st_q[vict] <= S_SYN; stamp_q[vict] <= tick;
        ackv_q[vict][0] <= 1'b0; ackv_q[vict][1] <= 1'b0;
        winv_q[vict][0] <= 1'b0; winv_q[vict][1] <= 1'b1; win_q[vict][1] <= pwin;
        ttlv_q[vict][0] <= 1'b0; ttlv_q[vict][1] <= 1'b1; ttl_q[vict][1] <= pttl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_hit <= 1'b0; res_new <= 1'b0; res_slot <= '0;
      res_fwd <= 1'b0; res_est <= 1'b0; res_c2s <= 1'b0; res_alert <= '0;
    end else begin
      res_valid <= busy;
      if (busy) begin
        res_hit   <= hit;
        res_new   <= do_new;
        res_slot  <= hit ? hidx : (do_new ? vict : '0);
        res_fwd   <= hit || cfg_miss_pass;
        res_est   <= hit && (st_q[hidx] == S_EST);
        res_c2s   <= hit ? hfwd : bare_syn;
        res_alert <= hit ? {al_ttl, al_win, al_seq} : 3'b000;
      end
    end
  end
endmodule

// File: rtl/tcp_flow_tracker_chk.sv
module tcp_flow_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       res_valid,
  input logic       res_hit,
  input logic       res_new,
  input logic       res_fwd,
  input logic       res_est,
  input logic       res_c2s,
  input logic [2:0] res_alert
);
  a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
  a_r13_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ##1 res_valid);
  a_r13_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r2_est_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_est |-> res_hit);
  a_r5_hit_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_fwd);
  a_r6_alert_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_alert == 3'b000);
  a_r10_new_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_new |-> !res_hit && res_c2s && !res_est);
endmodule

bind tcp_flow_tracker tcp_flow_tracker_chk u_chk (.*);

// File: tb/tcp_flow_tracker_tb.sv
module tcp_flow_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_proto = 8'd6;
  logic [31:0] in_src_ip = '0, in_dst_ip = '0;
  logic [15:0] in_src_port = '0, in_dst_port = '0;
  logic in_syn = 1'b0, in_ack_flag = 1'b0, in_rst = 1'b0;
  logic [31:0] in_seq = '0, in_ack = '0;
  logic [15:0] in_len = '0, in_win = '0;
  logic [7:0] in_ttl = '0, cfg_ttl_thresh = 8'd5;
  logic cfg_miss_pass = 1'b1;
  logic res_valid, res_hit, res_new, res_fwd, res_est, res_c2s;
  logic [SW-1:0] res_slot;
  logic [2:0] res_alert;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcp_flow_tracker #(.N(N), .TW(32), .TO_EMB(60), .TO_EST(400)) u_dut (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pkt(input int c, input bit fwd, input bit syn, input bit ackf, input bit rst,
                     input logic [31:0] seq, input logic [31:0] ack, input logic [15:0] len,
                     input logic [15:0] win, input logic [7:0] ttl);
    logic [31:0] cip = 32'h0A00_0000 + 32'(c);
    logic [15:0] cpt = 16'(1000 + c);
    @(negedge clk);
    chk("R13 ready before offer", in_ready, 1);
    in_valid = 1'b1;
    in_src_ip = fwd ? cip : 32'h0A00_0101;  in_dst_ip = fwd ? 32'h0A00_0101 : cip;
    in_src_port = fwd ? cpt : 16'd80;       in_dst_port = fwd ? 16'd80 : cpt;
    in_syn = syn; in_ack_flag = ackf; in_rst = rst;
    in_seq = seq; in_ack = ack; in_len = len; in_win = win; in_ttl = ttl;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R13 busy after accept", in_ready, 0);
    chk("R13 no early result", res_valid, 0);
    @(negedge clk);
    chk("R13 result strobe", res_valid, 1);
  endtask

  task automatic expect_res(input string r, input int hit, input int nw, input int slot,
                            input int fwd, input int est, input int c2s, input int al);
    chk({r, " hit"}, res_hit, hit);
    chk({r, " new"}, res_new, nw);
    chk({r, " slot"}, res_slot, slot);
    chk({r, " fwd"}, res_fwd, fwd);
    chk({r, " est"}, res_est, est);
    chk({r, " c2s"}, res_c2s, c2s);
    chk({r, " alert"}, res_alert, al);
  endtask

  task automatic open_session(input int c);
    pkt(c, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    pkt(c, 0, 1, 1, 0, 900, 101, 0, 2000, 50);
    pkt(c, 1, 0, 1, 0, 101, 901, 0, 1000, 64);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1 ready after reset", in_ready, 1);
    chk("R1 no result after reset", res_valid, 0);

    pkt(1, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    expect_res("R1 R2 R3 first SYN", 0, 1, 0, 1, 0, 1, 0);
    pkt(1, 0, 1, 1, 0, 900, 101, 0, 2000, 50);
    expect_res("R2 R3 SYN+ACK reversed", 1, 0, 0, 1, 0, 0, 0);
    pkt(1, 1, 0, 1, 0, 101, 901, 0, 1000, 64);
    expect_res("R2 final ACK", 1, 0, 0, 1, 0, 1, 0);
    pkt(1, 1, 0, 1, 0, 101, 901, 10, 1000, 64);
    expect_res("R2 established data", 1, 0, 0, 1, 1, 1, 0);

    for (int s = 91; s <= 111; s++) begin
      pkt(1, 1, 0, 1, 0, 32'(s), 901, 0, 1000, 64);
      chk("R6 sequence sweep", res_alert, (s < 101) ? 1 : 0);
    end
    for (int l = 1995; l <= 2005; l++) begin
      pkt(1, 1, 0, 1, 0, 101, 901, 16'(l), 1000, 64);
      chk("R7 window sweep", res_alert, (l > 2000) ? 2 : 0);
    end
    for (int t = 54; t <= 74; t++) begin
      pkt(1, 1, 0, 1, 0, 101, 901, 0, 1000, 8'(t));
      chk("R8 ttl sweep", res_alert, ((t - 64 > 5) || (64 - t > 5)) ? 4 : 0);
    end
    pkt(1, 0, 0, 1, 0, 800, 101, 1001, 2000, 50);
    expect_res("R6 R7 both alerts reversed", 1, 0, 0, 1, 1, 0, 3);

    pkt(1, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    expect_res("R4 SYN on established key", 0, 1, 1, 1, 0, 1, 0);

    cfg_miss_pass = 1'b0;
    pkt(9, 1, 0, 1, 0, 5, 5, 0, 1000, 64);
    expect_res("R5 miss dropped", 0, 0, 0, 0, 0, 0, 0);
    cfg_miss_pass = 1'b1;
    pkt(9, 1, 0, 1, 0, 5, 5, 0, 1000, 64);
    expect_res("R5 miss forwarded", 0, 0, 0, 1, 0, 0, 0);
    pkt(9, 0, 1, 1, 0, 5, 5, 0, 1000, 64);
    expect_res("R5 SYN+ACK miss no slot", 0, 0, 0, 1, 0, 0, 0);

    do_reset();
    open_session(1);
    pkt(2, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    chk("R12 second session slot", res_slot, 1);
    pkt(1, 1, 0, 1, 1, 101, 901, 0, 1000, 64);
    expect_res("R12 RST hit", 1, 0, 0, 1, 1, 1, 0);
    pkt(1, 1, 0, 1, 0, 101, 901, 0, 1000, 64);
    chk("R12 freed key misses", res_hit, 0);
    pkt(3, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    expect_res("R12 freed slot reused", 0, 1, 0, 1, 0, 1, 0);

    do_reset();
    for (int c = 1; c <= 4; c++) open_session(c);
    pkt(1, 1, 0, 1, 0, 101, 901, 0, 1000, 64);
    chk("R11 touch oldest", res_hit, 1);
    pkt(5, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    expect_res("R11 R10 LRU victim", 0, 1, 1, 1, 0, 1, 0);
    pkt(2, 1, 0, 1, 0, 101, 901, 0, 1000, 64);
    chk("R11 evicted key misses", res_hit, 0);
    pkt(1, 1, 0, 1, 0, 101, 901, 0, 1000, 64);
    chk("R11 refreshed key kept", res_hit, 1);

    do_reset();
    for (int c = 1; c <= 4; c++) pkt(c, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    pkt(5, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    expect_res("R10 full of embryonic", 0, 0, 0, 1, 0, 1, 0);

    do_reset();
    open_session(1);
    pkt(2, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    pkt(2, 0, 1, 1, 0, 900, 101, 0, 2000, 50);
    pkt(3, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    pkt(4, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    chk("R10 table filled", res_slot, 3);
    repeat (100) @(negedge clk);
    pkt(3, 1, 0, 1, 0, 101, 901, 0, 1000, 64);
    chk("R9 expired SYN-wait misses", res_hit, 0);
    pkt(2, 0, 1, 1, 0, 900, 101, 0, 2000, 50);
    expect_res("R9 expired ACK-wait misses", 0, 0, 0, 1, 0, 0, 0);
    pkt(1, 1, 0, 1, 0, 101, 901, 0, 1000, 64);
    expect_res("R9 established still live", 1, 0, 0, 1, 1, 1, 0);
    pkt(5, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    expect_res("R10 oldest expired SYN-wait", 0, 1, 2, 1, 0, 1, 0);
    pkt(6, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    expect_res("R10 next expired SYN-wait", 0, 1, 3, 1, 0, 1, 0);
    pkt(7, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    expect_res("R10 expired ACK-wait", 0, 1, 1, 1, 0, 1, 0);
    pkt(8, 1, 1, 0, 0, 100, 0, 0, 1000, 64);
    expect_res("R10 established LRU fallback", 0, 1, 0, 1, 0, 1, 0);

    finish_run();
  end
endmodule